// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the slave-side command engine of a small serial non-volatile memory reached over SPI. The SPI pins are oversampled by a fast system clock. The block decodes an 8-bit opcode, collects a 16-bit address and serves sequential array reads. It also handles page writes of up to one page, and reads and writes a status byte. The status byte holds a busy flag, a write-enable latch, two block-protect bits and two watchdog-interval bits.

Writes are staged in a page buffer and committed by a self-timed write cycle, which a cycle counter models. A write commits only when chip select is released on a whole-byte boundary after at least one data byte. The write-enable latch must be set, no cycle may already be running, the write-protect pin must be high, and for array writes the target page must lie outside the protected region. The serial output is enabled only while read data or status is being shifted out.

Top module: `spi_cmd_mem`

## Requirements
- R1: After reset the serial output enable is low and the status byte reads 0x00.
- R2: Opcode 0x03 followed by two address bytes (high byte first) returns array bytes MSB first. Each byte is driven after SCK falling edges and valid at the following rising edge. The address increments and wraps at the end of the array. The output enable is low whenever chip select is inactive.
- R3: Opcode 0x06 sets the write-enable latch, which is status bit 1. Opcode 0x04 clears it.
- R4: A write (opcode 0x02) or status write (opcode 0x01) issued while the latch is clear changes nothing and starts no write cycle.
- R5: A write cycle starts only when chip select rises after a whole number of data bytes, at least one. A rise after zero data bytes or after a partial byte aborts the write and leaves memory unchanged.
- R6: Write data fills consecutive addresses and wraps to the start of the same 32-byte page. Up to 32 bytes can be written in one command.
- R7: Status bit 0 is high for WRITE_CYC clock cycles after a commit. During that time opcode 0x05 still returns the status, and every other opcode is ignored, with the output enable kept low.
- R8: The write-enable latch clears when a write cycle completes.
- R9: A status write takes data bits 3:2 as block-protect bits and bits 5:4 as watchdog bits, and ignores data bits 1:0 and 7:6. The new value shows in the status byte once the cycle ends.
- R10: Block-protect bits 00/01/10/11 protect nothing, the upper quarter, the upper half, or the whole array. A write to a protected page starts no cycle and keeps the latch set.
- R11: While write-protect is low, neither array nor status writes start a cycle.
- R12: SPI modes 0 (SCK idle low) and 3 (SCK idle high) both work for writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Tri-state enable for so |

## Verification
Every page of the array is written with a distinct arithmetic pattern, alternating SPI mode 0 and mode 3. The array is then read back in one long burst that runs past the end. This separates address-increment, byte-order and wrap faults from mode-dependent edge handling. Writes that start near a page end show whether wrapping stays inside the page. Chip-select releases after zero bytes, after a partial byte and after whole bytes separate the commit rule from the abort paths. The protect settings are each probed on both sides of their boundary, with and without the write-protect pin, to tell the protect decode apart from the general write gating.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRW, ST_SRR, ST_IGN
  } cmd_st_e;

  // top2: two most significant array address bits of the target page
  function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = (top2 == 2'b11);
      2'b10:   prot_hit = top2[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_end,
  output logic si_s,
  output logic wp_ok
);
  // bit order: {wp_n, si, cs_n, sck}
  localparam logic [3:0] RST_V = 4'b1010;
  logic [3:0] stg [STAGES];
  logic       sck_d, csn_d;
  logic [3:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      stg[0] <= {wp_n, si, cs_n, sck};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sck_d <= stg[STAGES-1][0];
      csn_d <= stg[STAGES-1][1];
    end
  end

  assign last     = stg[STAGES-1];
  assign sck_rise = last[0] & ~sck_d;
  assign sck_fall = ~last[0] & sck_d;
  assign cs_act   = ~last[1];
  assign cs_end   = last[1] & ~csn_d;
  assign si_s     = last[2];
  assign wp_ok    = last[3];
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_wtimer.sv
module spi_mem_wtimer #(
  parameter int CYCLES = 250000,
  localparam int CW = $clog2(CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [CW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == CW'(CYCLES - 1)) busy <= 1'b0;
      else                        idx  <= idx + 1'b1;
    end
  end

  assign last = busy && (idx == CW'(CYCLES - 1));
endmodule

// File: rtl/spi_cmd_mem.sv
module spi_cmd_mem
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEPTH     = 256,
  parameter int PAGE      = 32,
  parameter int WRITE_CYC = 250000,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = $clog2(PAGE);
  localparam int ABYTES = ADDR_W / 8;
  localparam int ACW    = $clog2(ABYTES) + 1;
  localparam int CW     = $clog2(WRITE_CYC);

  logic sck_rise, sck_fall, cs_act, cs_end, si_s, wp_ok;
  spi_mem_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_end(cs_end), .si_s(si_s), .wp_ok(wp_ok)
  );

  cmd_st_e        st;
  logic [2:0]     bcnt;
  logic [6:0]     sh;
  logic [7:0]     op;
  logic [AW-1:0]  addr;
  logic [ACW-1:0] acnt;
  logic           got, wel, sr_cyc;
  logic [1:0]     bp, wd;
  logic [3:0]     sr_stage;
  logic [PAGE-1:0] pvalid;
  logic [7:0]     pbuf [PAGE];
  logic [7:0]     byte_in, rdata, status, out_byte;
  logic           wip, tm_last, start, wr_ok, sr_ok, mem_we, byte_done;
  logic [CW-1:0]  tm_idx;

  assign byte_in   = {sh, si_s};
  assign byte_done = cs_act && sck_rise && (bcnt == 3'd7);
  assign status    = {2'b00, wd, bp, wel, wip};

  // commit gating evaluated in the first cycle chip select is seen released
  assign wr_ok = (st == ST_WDAT) && got && (bcnt == 3'd0) && wel && wp_ok && !wip
                 && !prot_hit(bp, addr[AW-1:AW-2]);
  assign sr_ok = (st == ST_SRW) && got && (bcnt == 3'd0) && wel && wp_ok && !wip;
  assign start = cs_end && (wr_ok || sr_ok);

  spi_mem_wtimer #(.CYCLES(WRITE_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(wip), .idx(tm_idx), .last(tm_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_CMD; bcnt <= '0; sh <= '0; op <= '0; addr <= '0; acnt <= '0;
      got <= 1'b0; wel <= 1'b0; sr_cyc <= 1'b0; bp <= '0; wd <= '0;
      sr_stage <= '0; pvalid <= '0;
    end else begin
      if (tm_last) begin
        wel    <= 1'b0;
        pvalid <= '0;
        sr_cyc <= 1'b0;
        if (sr_cyc) {wd, bp} <= sr_stage;
      end
      if (!cs_act) begin
        st <= ST_CMD; bcnt <= '0; acnt <= '0; got <= 1'b0;
        if (cs_end && sr_ok) sr_cyc <= 1'b1;
      end else if (sck_rise) begin
        sh   <= byte_in[6:0];
        bcnt <= bcnt + 1'b1;
        if (bcnt == 3'd7) begin
          case (st)
            ST_CMD: begin
              op <= byte_in;
              if (wip && byte_in != OP_RDSR) st <= ST_IGN;
              else begin
                case (byte_in)
                  OP_WREN: begin wel <= 1'b1; st <= ST_IGN; end
                  OP_WRDI: begin wel <= 1'b0; st <= ST_IGN; end
                  OP_RDSR: st <= ST_SRR;
                  OP_WRSR: st <= ST_SRW;
                  OP_READ, OP_WRITE: st <= ST_ADDR;
                  default: st <= ST_IGN;
                endcase
              end
            end
            ST_ADDR: begin
              addr <= AW'({addr, byte_in});
              acnt <= acnt + 1'b1;
              if (acnt == ACW'(ABYTES - 1)) begin
                st     <= (op == OP_READ) ? ST_RDAT : ST_WDAT;
                pvalid <= '0;
              end
            end
            ST_RDAT: addr <= addr + 1'b1;
            ST_WDAT: begin
              pvalid[addr[PW-1:0]] <= 1'b1;
              addr[PW-1:0]         <= addr[PW-1:0] + 1'b1;
              got                  <= 1'b1;
            end
            ST_SRW: begin
              sr_stage <= byte_in[5:2];
              got      <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // page buffer: no reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (byte_done && st == ST_WDAT) pbuf[addr[PW-1:0]] <= byte_in;
  end

  assign mem_we = wip && !sr_cyc && ({1'b0, tm_idx} < (CW+1)'(PAGE))
                  && pvalid[tm_idx[PW-1:0]];

  spi_mem_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(mem_we),
    .waddr({addr[AW-1:PW], tm_idx[PW-1:0]}), .wdata(pbuf[tm_idx[PW-1:0]]),
    .raddr(addr), .rdata(rdata)
  );

  assign out_byte = (st == ST_SRR) ? status : rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      so_oe <= cs_act && (st == ST_RDAT || st == ST_SRR);
      if (cs_act && sck_fall) so <= out_byte[3'd7 - bcnt];
    end
  end
endmodule

// File: rtl/spi_cmd_mem_chk.sv
module spi_cmd_mem_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic cs_end,
  input logic wp_ok,
  input logic so_oe,
  input logic wip,
  input logic wel
);
  assert_oe_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe);
  assert_start_on_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_end));
  assert_start_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel));
  assert_wel_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);
  assert_wp_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wp_ok));
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (wip && $past(wip)) |-> !$rose(wel));
endmodule

bind spi_cmd_mem spi_cmd_mem_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cs_end(cs_end), .wp_ok(wp_ok),
  .so_oe(so_oe), .wip(wip), .wel(wel)
);

// File: tb/spi_cmd_mem_tb.sv
module spi_cmd_mem_tb;
  localparam int HALF  = 6;
  localparam int WCYC  = 2000;
  localparam int DEPTH = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0, oe_seen = 1'b0, done = 1'b0;
  int   errors = 0, checks = 0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  spi_cmd_mem #(.ADDR_W(16), .DEPTH(DEPTH), .PAGE(32), .WRITE_CYC(WCYC), .SYNC(2)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      tick(HALF);
      sck = 1'b1;
      rx[i] = so;
      if (so_oe) oe_seen = 1'b1;
      tick(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic sel();
    sck = mode3;
    tick(2);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, 8, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] sr);
    logic [7:0] r;
    sel(); xfer(8'h05, 8, r); xfer(8'h00, 8, sr); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, 8, r); xfer(v, 8, r); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] sr;
    int polls = 0;
    do begin
      rdsr(sr);
      polls++;
    end while (sr[0] && polls < 60);
    chk("R7 busy ends", {31'd0, sr[0]}, 32'd0);
  endtask

  task automatic write_seq(input int a, input int n, input int v0, input int step, input int extra);
    logic [7:0] r;
    sel();
    xfer(8'h02, 8, r); xfer(8'(a >> 8), 8, r); xfer(8'(a), 8, r);
    for (int i = 0; i < n; i++) xfer(8'(v0 + i * step), 8, r);
    if (extra > 0) xfer(8'h5A, extra, r);
    desel();
  endtask

  task automatic model_wr(input int a, input int n, input int v0, input int step);
    for (int i = 0; i < n; i++)
      model[(a & ~31) + ((a + i) & 31)] = 8'(v0 + i * step);
  endtask

  task automatic read_chk(input int a, input int n, input string tag);
    logic [7:0] r;
    sel();
    xfer(8'h03, 8, r); xfer(8'(a >> 8), 8, r); xfer(8'(a), 8, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, r);
      chk(tag, {24'd0, r}, {24'd0, model[(a + i) % DEPTH]});
    end
    desel();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] sr, r;
    tick(10);
    rst = 1'b0;
    tick(4);
    chk("R1 so_oe after reset", {31'd0, so_oe}, 32'd0);
    rdsr(sr); chk("R1 status after reset", {24'd0, sr}, 32'h00);

    op1(8'h06); rdsr(sr); chk("R3 WREN sets latch", {24'd0, sr}, 32'h02);
    op1(8'h04); rdsr(sr); chk("R3 WRDI clears latch", {24'd0, sr}, 32'h00);

    // fill the whole array page by page, alternating modes 0 and 3
    for (int p = 0; p < DEPTH / 32; p++) begin
      mode3 = p[0];
      op1(8'h06);
      write_seq(p * 32, 32, p * 29 + 7, 13, 0);
      model_wr(p * 32, 32, p * 29 + 7, 13);
      rdsr(sr); chk("R7 busy and latch after commit R12", {24'd0, sr}, 32'h03);
      wait_ready();
      rdsr(sr); chk("R8 latch cleared after cycle", {24'd0, sr}, 32'h00);
    end
    mode3 = 1'b0;
    read_chk(0, DEPTH + 2, "R2 burst read with wrap");
    mode3 = 1'b1;
    read_chk(8'h55, 16, "R12 mode 3 read");
    mode3 = 1'b0;

    write_seq(5, 1, 8'hEE, 0, 0);
    rdsr(sr); chk("R4 no cycle without latch", {24'd0, sr}, 32'h00);
    read_chk(5, 1, "R4 memory unchanged");

    op1(8'h06);
    write_seq(8'h3E, 4, 8'hA0, 1, 0);
    model_wr(8'h3E, 4, 8'hA0, 1);
    wait_ready();
    read_chk(8'h20, 32, "R6 page wrap");

    op1(8'h06);
    write_seq(8'h70, 1, 8'h5A, 0, 0);
    model_wr(8'h70, 1, 8'h5A, 0);
    rdsr(sr); chk("R7 status readable while busy", {24'd0, sr}, 32'h03);
    sel(); xfer(8'h03, 8, r); xfer(8'h00, 8, r); xfer(8'h70, 8, r); xfer(8'h00, 8, r); desel();
    chk("R7 read ignored while busy", {31'd0, oe_seen}, 32'd0);
    op1(8'h04);
    rdsr(sr); chk("R7 WRDI ignored while busy", {24'd0, sr}, 32'h03);
    wait_ready();
    read_chk(8'h70, 1, "R7 write landed");

    op1(8'h06);
    write_seq(8'h40, 1, 8'h11, 0, 3);
    rdsr(sr); chk("R5 partial byte aborts", {24'd0, sr}, 32'h02);
    write_seq(8'h41, 0, 0, 0, 0);
    rdsr(sr); chk("R5 zero data aborts", {24'd0, sr}, 32'h02);
    read_chk(8'h40, 2, "R5 memory unchanged");
    write_seq(8'h40, 2, 8'h33, 1, 0);
    model_wr(8'h40, 2, 8'h33, 1);
    rdsr(sr); chk("R5 whole bytes commit", {24'd0, sr}, 32'h03);
    wait_ready();
    read_chk(8'h40, 2, "R5 committed data");

    op1(8'h06); wrsr(8'hFF);
    rdsr(sr); chk("R9 old value during cycle", {24'd0, sr}, 32'h03);
    wait_ready();
    rdsr(sr); chk("R9 status bits applied", {24'd0, sr}, 32'h3C);

    op1(8'h06);
    write_seq(8'h00, 1, 8'h99, 0, 0);
    rdsr(sr); chk("R10 all protected", {24'd0, sr}, 32'h3E);
    read_chk(0, 1, "R10 protected unchanged");

    wrsr(8'h04); wait_ready();
    rdsr(sr); chk("R9 quarter setting", {24'd0, sr}, 32'h04);
    op1(8'h06);
    write_seq(8'hC0, 1, 8'h77, 0, 0);
    rdsr(sr); chk("R10 upper quarter rejected", {24'd0, sr}, 32'h06);
    write_seq(8'hBF, 1, 8'h44, 0, 0);
    model_wr(8'hBF, 1, 8'h44, 0);
    rdsr(sr); chk("R10 below quarter accepted", {24'd0, sr}, 32'h07);
    wait_ready();
    read_chk(8'hBF, 2, "R10 quarter boundary");

    op1(8'h06); wrsr(8'h08); wait_ready();
    op1(8'h06);
    write_seq(8'h80, 1, 8'h66, 0, 0);
    rdsr(sr); chk("R10 upper half rejected", {24'd0, sr}, 32'h0A);
    write_seq(8'h7F, 1, 8'h55, 0, 0);
    model_wr(8'h7F, 1, 8'h55, 0);
    wait_ready();
    read_chk(8'h7F, 2, "R10 half boundary");

    op1(8'h06); wrsr(8'hF3); wait_ready();
    rdsr(sr); chk("R9 watchdog bits only", {24'd0, sr}, 32'h30);
    op1(8'h06);
    write_seq(8'hFF, 1, 8'h12, 0, 0);
    model_wr(8'hFF, 1, 8'h12, 0);
    wait_ready();
    read_chk(8'hFF, 1, "R10 none protected");

    wp_n = 1'b0;
    op1(8'h06); wrsr(8'h0C);
    rdsr(sr); chk("R11 status write blocked", {24'd0, sr}, 32'h32);
    write_seq(8'h10, 1, 8'hAB, 0, 0);
    rdsr(sr); chk("R11 array write blocked", {24'd0, sr}, 32'h32);
    read_chk(8'h10, 1, "R11 memory unchanged");
    wp_n = 1'b1;
    wrsr(8'h00); wait_ready();
    rdsr(sr); chk("R8 final status", {24'd0, sr}, 32'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule